// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Emulator

This block behaves as a small serial EEPROM: a word store of `2**ADDR_W` entries, 16 bits each, reached over a chip-select, serial-clock and serial-data interface. A host raises chip select and shifts in an instruction on rising serial-clock edges, MSB first. The instruction is a start bit of 1, a 2-bit operation code and an address field, and for the two write forms it is followed by 16 data bits. The emulator can then return a stored word, program one word, erase one word, fill or clear the whole store, or switch programming permission on or off. All pins are sampled in the system clock domain through a short synchroniser, and serial-clock rising edges are detected there.

The decoder is a state machine with these states:

- `ST_IDLE` waits for a start bit.
- `ST_OPCODE` collects the two operation bits.
- `ST_ADDR` collects the address.
- `ST_DATA` collects the 16 data bits.
- `ST_READ` shifts the stored word out.
- `ST_DONE` holds until chip select falls.

Its transitions are:

- start (`ST_IDLE`→`ST_OPCODE`) on a sampled 1 while the store is not busy.
- op_done (`ST_OPCODE`→`ST_ADDR`) after the second operation bit.
- addr_to_read, addr_to_data and addr_to_done from `ST_ADDR`, chosen by the decoded operation.
- data_done (`ST_DATA`→`ST_DONE`).
- read_done (`ST_READ`→`ST_DONE`) after the last data bit.
- abort (any state→`ST_IDLE`) when chip select is low.

A programming operation takes effect on the rising edge that samples its last bit. It then starts a busy timer that runs for `PROG_CYCLES` system clocks. While chip select is high in `ST_IDLE` or `ST_DONE`, the serial output shows the ready status.

Top module: `mw_eeprom_emu`

## Requirements
- R1: While idle with chip select high, a sampled 0 on the serial input is ignored. The first sampled 1 is taken as the start bit.
- R2: Operation code 2'b10 with an address reads a word. The serial output goes to 0 at the edge that samples the last address bit. Each following rising edge then presents the next word bit, MSB first, for 16 bits.
- R3: Operation code 2'b01, an address and 16 data bits (MSB first) store the data at that address when programming is enabled.
- R4: Operation code 2'b11 with an address sets that word to 16'hFFFF when programming is enabled.
- R5: For operation code 2'b00, the two most significant address bits select the function: 2'b11 enables programming and 2'b00 disables it. The remaining address bits are don't care.
- R6: Operation code 2'b00 with top address bits 2'b10 sets every word to 16'hFFFF when programming is enabled.
- R7: Operation code 2'b00 with top address bits 2'b01, followed by 16 data bits, writes those data into every word when programming is enabled.
- R8: After reset, programming is disabled, every word reads 16'hFFFF, and the serial output is 0 while chip select is low.
- R9: While programming is disabled, write, erase, erase-all and write-all leave the store unchanged.
- R10: Chip select low aborts a partial instruction with no effect and returns the decoder to wait for a start bit.
- R11: After a programming operation, the serial output reads 0 (busy) for `PROG_CYCLES` clocks while chip select is high and no read is shifting, and 1 (ready) afterwards. Start bits that arrive while busy are ignored.
- R12: The address field is `ADDR_W` bits (6 or 8), sent MSB first. Word 0 and word `2**ADDR_W-1` are both reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel | input | 1 | Chip select, active high |
| ser_clk | input | 1 | Serial clock; bits are taken on its rising edge |
| ser_in | input | 1 | Serial instruction, address and data input |
| ser_out | output | 1 | Read data, or ready status when not reading |

## Verification
Two functions can fall in the same cycle: a start bit being recognised, and the busy timer still running from the previous write. The bench provokes this by finishing a write, briefly dropping chip select, and at once clocking in a complete erase of word 0 inside the busy window. It judges the result by reading word 0 back unchanged after the timer has expired. A second overlap is a chip-select drop in the middle of a write's data field. The bench checks that this drop cancels the store and that the next instruction still decodes.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } mw_state_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } mw_op_e;

    typedef enum logic [1:0] {
        EXT_LOCK   = 2'b00,
        EXT_FILL   = 2'b01,
        EXT_CLEAR  = 2'b10,
        EXT_UNLOCK = 2'b11
    } mw_ext_e;

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_raw,
    input  logic sk_raw,
    input  logic di_raw,
    output logic cs_s,
    output logic di_s,
    output logic sk_rise
);
    logic [STAGES-1:0] cs_p, sk_p, di_p;
    logic              sk_last;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        cs_p[0] <= 1'b0;
                        sk_p[0] <= 1'b0;
                        di_p[0] <= 1'b0;
                    end else begin
                        cs_p[0] <= cs_raw;
                        sk_p[0] <= sk_raw;
                        di_p[0] <= di_raw;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        cs_p[g] <= 1'b0;
                        sk_p[g] <= 1'b0;
                        di_p[g] <= 1'b0;
                    end else begin
                        cs_p[g] <= cs_p[g-1];
                        sk_p[g] <= sk_p[g-1];
                        di_p[g] <= di_p[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_last <= 1'b0;
        else        sk_last <= sk_p[STAGES-1];
    end

    assign cs_s    = cs_p[STAGES-1];
    assign di_s    = di_p[STAGES-1];
    assign sk_rise = sk_p[STAGES-1] & ~sk_last;

endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_one,
    input  logic              wr_all,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) cells[w] <= '1;
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (wr_all || (wr_one && wr_addr == ADDR_W'(w)))
                    cells[w] <= wr_data;
            end
        end
    end

    assign rd_data = cells[rd_addr];

    // R9
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_one && !wr_all) |=> $stable(cells[0]))
        else $error("word 0 changed without a write strobe");

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            remain <= '0;
        else if (start)        remain <= CW'(PROG_CYCLES);
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy)
        else $error("timer not busy after a programming start");

    // R11
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start))
        else $error("busy rose without a programming start");

endmodule

// File: rtl/mw_eeprom_emu.sv
module mw_eeprom_emu
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chip_sel,
    input  logic ser_clk,
    input  logic ser_in,
    output logic ser_out
);
    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] READ_LAST = CNT_W'(DATA_W);

    logic              cs_s, di_s, sk_rise;
    logic              busy;
    mw_state_e         state, state_n;
    mw_op_e            op_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] addr_q, addr_full;
    logic [DATA_W-1:0] data_q, data_full;
    logic [DATA_W:0]   rd_shift;
    logic              wen_q;
    mw_ext_e           ext;
    logic              last_addr_ev, last_data_ev;
    logic              mem_wr_one, mem_wr_all;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [DATA_W-1:0] mem_wr_data, mem_rd_data;

    mw_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_raw  (chip_sel),
        .sk_raw  (ser_clk),
        .di_raw  (ser_in),
        .cs_s    (cs_s),
        .di_s    (di_s),
        .sk_rise (sk_rise)
    );

    // Event decode shared by next-state and output logic
    always_comb begin
        addr_full    = {addr_q[ADDR_W-2:0], di_s};
        data_full    = {data_q[DATA_W-2:0], di_s};
        ext          = mw_ext_e'(addr_full[ADDR_W-1:ADDR_W-2]);
        last_addr_ev = cs_s && sk_rise && (state == ST_ADDR) && (bit_cnt == ADDR_LAST);
        last_data_ev = cs_s && sk_rise && (state == ST_DATA) && (bit_cnt == DATA_LAST);
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        if (!cs_s) begin
            state_n = ST_IDLE;
        end else if (sk_rise) begin
            unique case (state)
                ST_IDLE: begin
                    if (di_s && !busy) state_n = ST_OPCODE;
                end
                ST_OPCODE: begin
                    if (bit_cnt == CNT_W'(1)) state_n = ST_ADDR;
                end
                ST_ADDR: begin
                    if (bit_cnt == ADDR_LAST) begin
                        unique case (op_q)
                            OP_READ:  state_n = ST_READ;
                            OP_WRITE: state_n = ST_DATA;
                            OP_ERASE: state_n = ST_DONE;
                            OP_EXT:   state_n = (ext == EXT_FILL) ? ST_DATA : ST_DONE;
                            default:  state_n = ST_DONE;
                        endcase
                    end
                end
                ST_DATA: begin
                    if (bit_cnt == DATA_LAST) state_n = ST_DONE;
                end
                ST_READ: begin
                    if (bit_cnt == READ_LAST) state_n = ST_DONE;
                end
                ST_DONE: state_n = ST_DONE;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Shift registers, bit counter and permission flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            op_q     <= OP_EXT;
            addr_q   <= '0;
            data_q   <= '0;
            rd_shift <= '0;
            wen_q    <= 1'b0;
        end else begin
            if (state_n != state)
                bit_cnt <= '0;
            else if (cs_s && sk_rise && state != ST_IDLE && state != ST_DONE)
                bit_cnt <= bit_cnt + 1'b1;

            if (cs_s && sk_rise) begin
                unique case (state)
                    ST_OPCODE: op_q   <= mw_op_e'({op_q[0], di_s});
                    ST_ADDR:   addr_q <= addr_full;
                    ST_DATA:   data_q <= data_full;
                    ST_READ:   rd_shift <= {rd_shift[DATA_W-1:0], 1'b0};
                    default:   ;
                endcase
            end

            if (last_addr_ev && op_q == OP_READ)
                rd_shift <= {1'b0, mem_rd_data};

            if (last_addr_ev && op_q == OP_EXT) begin
                if (ext == EXT_UNLOCK)    wen_q <= 1'b1;
                else if (ext == EXT_LOCK) wen_q <= 1'b0;
            end
        end
    end

    // Outputs: store strobes and serial output
    always_comb begin
        mem_wr_one  = 1'b0;
        mem_wr_all  = 1'b0;
        mem_wr_data = data_full;
        mem_wr_addr = (state == ST_ADDR) ? addr_full : addr_q;
        if (wen_q) begin
            unique case (op_q)
                OP_WRITE: mem_wr_one = last_data_ev;
                OP_ERASE: begin
                    mem_wr_one  = last_addr_ev;
                    mem_wr_data = '1;
                end
                OP_EXT: begin
                    if (state == ST_DATA) begin
                        mem_wr_all = last_data_ev;
                    end else if (ext == EXT_CLEAR) begin
                        mem_wr_all  = last_addr_ev;
                        mem_wr_data = '1;
                    end
                end
                default: ;
            endcase
        end

        if (state == ST_READ)
            ser_out = rd_shift[DATA_W];
        else if (cs_s && (state == ST_IDLE || state == ST_DONE))
            ser_out = ~busy;
        else
            ser_out = 1'b0;
    end

    mw_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_one  (mem_wr_one),
        .wr_all  (mem_wr_all),
        .wr_addr (mem_wr_addr),
        .wr_data (mem_wr_data),
        .rd_addr (addr_full),
        .rd_data (mem_rd_data)
    );

    mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mem_wr_one | mem_wr_all),
        .busy  (busy)
    );

    // R10
    cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> (state == ST_IDLE))
        else $error("decoder not idle after chip select low");

    // R2
    dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && $past(state) != ST_READ) |-> !ser_out)
        else $error("read did not start with a zero bit");

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && busy) |=> (state == ST_IDLE))
        else $error("start bit accepted while busy");

endmodule

// File: tb/test_mw_eeprom_emu.sv
module test_mw_eeprom_emu;

    localparam int AW   = 6;
    localparam int PROG = 200;
    localparam int NW   = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip_sel = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_in = 1'b0;
    logic ser_out;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        string       tag;
        logic [15:0] val;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] obs_q[$];
    logic [15:0] mdl [NW];
    logic        mdl_en;

    always #4 clk = ~clk;

    mw_eeprom_emu #(.ADDR_W(AW), .DATA_W(16), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) i_mw_eeprom_emu (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_sel (chip_sel),
        .ser_clk  (ser_clk),
        .ser_in   (ser_in),
        .ser_out  (ser_out)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic clk_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_bit(input logic b);
        ser_in  = b;
        ser_clk = 1'b0;
        clk_wait(4);
        ser_clk = 1'b1;
        clk_wait(6);
    endtask

    task automatic cs_up();
        ser_clk  = 1'b0;
        chip_sel = 1'b1;
        clk_wait(4);
    endtask

    task automatic cs_down();
        ser_clk  = 1'b0;
        chip_sel = 1'b0;
        clk_wait(4);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a);
        sk_bit(1'b1);
        sk_bit(op[1]);
        sk_bit(op[0]);
        for (int i = AW - 1; i >= 0; i--) sk_bit(a[i]);
    endtask

    // Model of the programming effect, from the requirements
    task automatic model_apply(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] d);
        case (op)
            2'b01: if (mdl_en) mdl[a] = d;
            2'b11: if (mdl_en) mdl[a] = 16'hFFFF;
            2'b00: begin
                case (a[AW-1:AW-2])
                    2'b11: mdl_en = 1'b1;
                    2'b00: mdl_en = 1'b0;
                    2'b10: if (mdl_en) for (int w = 0; w < NW; w++) mdl[w] = 16'hFFFF;
                    default: if (mdl_en) for (int w = 0; w < NW; w++) mdl[w] = d;
                endcase
            end
            default: ;
        endcase
    endtask

    task automatic prog(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] d);
        logic has_data;
        has_data = (op == 2'b01) || (op == 2'b00 && a[AW-1:AW-2] == 2'b01);
        cs_up();
        send_hdr(op, a);
        if (has_data) for (int i = 15; i >= 0; i--) sk_bit(d[i]);
        cs_down();
        model_apply(op, a, d);
        clk_wait(PROG + 20);
    endtask

    task automatic read_word(input logic [AW-1:0] a, input string tag);
        logic [15:0] w;
        exp_t e;
        e.tag = tag;
        e.val = mdl[a];
        exp_q.push_back(e);
        cs_up();
        send_hdr(2'b10, a);
        // R2: leading dummy zero
        check(ser_out == 1'b0, "R2 dummy zero", {15'd0, ser_out}, 16'h0000);
        for (int i = 15; i >= 0; i--) begin
            sk_bit(1'b0);
            w[i] = ser_out;
        end
        obs_q.push_back(w);
        cs_down();
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            wait (obs_q.size() > 0);
            begin
                logic [15:0] got;
                exp_t e;
                got = obs_q.pop_front();
                e   = exp_q.pop_front();
                check(got === e.val, e.tag, got, e.val);
            end
        end
    end

    // Watchdog
    initial begin
        clk_wait(150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
        finish_run();
    end

    initial begin
        for (int w = 0; w < NW; w++) mdl[w] = 16'hFFFF;
        mdl_en = 1'b0;
        clk_wait(5);
        rst_n = 1'b1;
        clk_wait(5);

        // R8: output low with chip select low after reset
        check(ser_out == 1'b0, "R8 idle output", {15'd0, ser_out}, 16'h0000);
        // R11: ready status shown when not busy
        cs_up();
        check(ser_out == 1'b1, "R11 ready at reset", {15'd0, ser_out}, 16'h0001);
        cs_down();

        // R8: erased contents after reset
        read_word(6'd5, "R8 erased after reset");

        // R8 / R9: write before enable is ignored
        prog(2'b01, 6'd3, 16'h1234);
        read_word(6'd3, "R9 write while disabled");

        // R5: enable programming
        prog(2'b00, 6'b110000, 16'h0);

        // R3 and R11: write, busy then ready with chip select held high
        cs_up();
        send_hdr(2'b01, 6'd3);
        for (int i = 15; i >= 0; i--) sk_bit(16'hA5C3 >> i);
        check(ser_out == 1'b0, "R11 busy after write", {15'd0, ser_out}, 16'h0000);
        model_apply(2'b01, 6'd3, 16'hA5C3);
        clk_wait(PROG + 10);
        check(ser_out == 1'b1, "R11 ready after timer", {15'd0, ser_out}, 16'h0001);
        cs_down();
        read_word(6'd3, "R3 write word 3");

        // R12: boundary addresses
        prog(2'b01, 6'd0, 16'h0001);
        prog(2'b01, 6'd63, 16'h8000);
        read_word(6'd0, "R12 word 0");
        read_word(6'd63, "R12 top word");

        // R1: leading zeros before the start bit
        cs_up();
        sk_bit(1'b0);
        sk_bit(1'b0);
        sk_bit(1'b0);
        send_hdr(2'b01, 6'd10);
        for (int i = 15; i >= 0; i--) sk_bit(16'hBEEF >> i);
        cs_down();
        model_apply(2'b01, 6'd10, 16'hBEEF);
        clk_wait(PROG + 20);
        read_word(6'd10, "R1 leading zeros ignored");

        // R4: erase one word
        prog(2'b11, 6'd3, 16'h0);
        read_word(6'd3, "R4 erase word 3");

        // R10: abort in the middle of the data field
        cs_up();
        send_hdr(2'b01, 6'd10);
        for (int i = 0; i < 8; i++) sk_bit(1'b0);
        cs_down();
        clk_wait(PROG + 20);
        read_word(6'd10, "R10 aborted write");

        // R11: instruction clocked in while busy is ignored
        cs_up();
        send_hdr(2'b01, 6'd20);
        for (int i = 15; i >= 0; i--) sk_bit(16'h1111 >> i);
        cs_down();
        model_apply(2'b01, 6'd20, 16'h1111);
        cs_up();
        send_hdr(2'b11, 6'd0);
        cs_down();
        clk_wait(PROG + 20);
        read_word(6'd0, "R11 erase ignored while busy");
        read_word(6'd20, "R11 write before busy window");

        // R7: write all
        prog(2'b00, 6'b010000, 16'h5A5A);
        read_word(6'd0, "R7 fill word 0");
        read_word(6'd33, "R7 fill word 33");
        read_word(6'd63, "R7 fill top word");

        // R6: erase all
        prog(2'b00, 6'b100000, 16'h0);
        read_word(6'd7, "R6 clear word 7");
        read_word(6'd63, "R6 clear top word");

        // R5 / R9: disable, then every programming form is ignored
        prog(2'b01, 6'd7, 16'h0F0F);
        prog(2'b00, 6'b000000, 16'h0);
        prog(2'b01, 6'd7, 16'h7777);
        prog(2'b11, 6'd7, 16'h0);
        prog(2'b00, 6'b100000, 16'h0);
        prog(2'b00, 6'b010000, 16'h3333);
        read_word(6'd7, "R9 locked word 7");
        read_word(6'd8, "R9 locked word 8");

        // R5: enable with don't-care low address bits set
        prog(2'b00, 6'b111111, 16'h0);
        prog(2'b01, 6'd9, 16'h2468);
        read_word(6'd9, "R5 enable with dont-care bits");

        wait (obs_q.size() == 0);
        clk_wait(2);
        check(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0000);
        finish_run();
    end

endmodule